// File: doc/BRIEF.md
# Repeating Bit-Pattern Clock Generator

This block makes a master clock for an image sensor. It does not count down a divider. Instead it plays back a stored, programmable 32-bit pattern and sends out one bit on every cycle of a fixed-rate input clock. After the last bit it starts the pattern again from the first bit, with no gap. By choosing the pattern and its length, software can produce any duty cycle or period that fits in the pattern. The default pattern of alternating ones and zeros gives a clock at half the input rate, for example 6 MHz from a 12 MHz source.

Software loads the pattern as two 16-bit halves and also sets a length limit, which is the index of the last bit played before the wrap. These writes go into staging registers. The running generator only picks them up when it is started, and each start resets the bit index to zero. A stop command halts the playback and holds the output low.

Top module: `pattern_clk_gen`

## Requirements
- R1: After synchronous reset, `pat_out` is 0 and the generator is stopped. The staged pattern is 0x55555555 and the staged length limit is 31.
- R2: After a start is sampled, `pat_out` is 0 for one cycle. After that it shows pattern bit 0, bit 1, and so on, least significant bit first, one bit per clock.
- R3: A write with `wr_sel` = 0 stages `wr_data` as pattern bits 15:0. A write with `wr_sel` = 1 stages `wr_data` as pattern bits 31:16.
- R4: A write with `wr_sel` = 2 stages `wr_data[4:0]` as the length limit L. Once started, bit L is followed directly by bit 0, so the output repeats with period L+1.
- R5: A stop that is sampled without a start drives `pat_out` to 0 from the next cycle. It stays 0 until the next start.
- R6: Writes made while the generator runs do not change the waveform being played. They take effect only at the next start.
- R7: A start while running reloads the staged values and restarts from bit 0. A start sampled together with a stop wins over the stop. A start uses the staged values from before any write in the same cycle.
- R8: A write with `wr_sel` = 3 changes nothing.
- R9: With the default pattern and limit, a started generator toggles `pat_out` on every clock, beginning with a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_sel | input | 2 | Write target: 0 low half, 1 high half, 2 length limit, 3 none |
| wr_data | input | 16 | Write data |
| start | input | 1 | Load the staged settings and play from bit 0 |
| stop | input | 1 | Halt the playback and hold the output low |
| pat_out | output | 1 | Generated clock pattern |

## Verification
The default alternating pattern shows whether the output runs at half rate and starts with a 1. A short limit with a single set bit shows whether the wrap comes after exactly L+1 bits with no gap. Asymmetric patterns in the two halves show the bit order and whether the halves sit in the right places. Long random runs mix writes during playback, restarts and stops, and compare each output cycle with a reference model. These runs separate the staging behaviour and the start and stop priority from a design that applies writes at once. A write to selector 3 followed by a start shows whether that write left the staged settings untouched.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Write target selector encoding
    typedef enum logic [1:0] {
        SEL_PAT_LO = 2'd0,
        SEL_PAT_HI = 2'd1,
        SEL_LIMIT  = 2'd2,
        SEL_NONE   = 2'd3
    } pcg_sel_e;

    // Generator run state
    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } pcg_state_e;

    // Bound a requested limit to the last valid pattern position
    function automatic int unsigned clamp_limit(int unsigned req, int unsigned pat_w);
        return (req > pat_w - 1) ? pat_w - 1 : req;
    endfunction

endpackage

// File: rtl/pcg_cfg_bank.sv
module pcg_cfg_bank
    import pcg_pkg::*;
#(
    parameter int unsigned PAT_W   = 32,
    parameter int unsigned HALF_W  = 16,
    parameter int unsigned LIM_W   = 5,
    parameter logic [PAT_W-1:0] DEF_PAT = 32'h5555_5555,
    parameter logic [LIM_W-1:0] DEF_LIM = 5'd31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic [PAT_W-1:0]  stg_pat,
    output logic [LIM_W-1:0]  stg_lim
);
    localparam int unsigned NHALF = PAT_W / HALF_W;

    pcg_sel_e sel;
    assign sel = pcg_sel_e'(wr_sel);

    // One staging slice per pattern half
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic hit;
        assign hit = wr_en && (int'(sel) == h) && (sel != SEL_LIMIT) && (sel != SEL_NONE);
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_pat[h*HALF_W +: HALF_W] <= DEF_PAT[h*HALF_W +: HALF_W];
            end else if (hit) begin
                stg_pat[h*HALF_W +: HALF_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_lim <= DEF_LIM;
        end else if (wr_en && sel == SEL_LIMIT) begin
            stg_lim <= wr_data[LIM_W-1:0];
        end
    end

endmodule

// File: rtl/pcg_engine.sv
module pcg_engine
    import pcg_pkg::*;
#(
    parameter int unsigned PAT_W = 32,
    parameter int unsigned LIM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [PAT_W-1:0] stg_pat,
    input  logic [LIM_W-1:0] stg_lim,
    output logic             pat_out,
    output logic             running,
    output logic [LIM_W-1:0] idx,
    output logic [LIM_W-1:0] act_lim,
    output logic [PAT_W-1:0] act_pat
);
    localparam logic [LIM_W-1:0] LAST = LIM_W'(PAT_W - 1);

    pcg_state_e       state;
    logic [LIM_W-1:0] lim_in;
    logic [LIM_W-1:0] idx_nxt;
    logic             cur_bit;

    assign lim_in  = LIM_W'(clamp_limit(int'(stg_lim), PAT_W));
    assign idx_nxt = (idx == act_lim || idx == LAST) ? '0 : idx + 1'b1;
    assign cur_bit = act_pat[idx];
    assign running = (state == GEN_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= GEN_IDLE;
            idx     <= '0;
            act_pat <= '0;
            act_lim <= '0;
            pat_out <= 1'b0;
        end else if (start) begin
            state   <= GEN_RUN;
            idx     <= '0;
            act_pat <= stg_pat;
            act_lim <= lim_in;
            pat_out <= 1'b0;
        end else if (stop) begin
            state   <= GEN_IDLE;
            idx     <= '0;
            pat_out <= 1'b0;
        end else if (state == GEN_RUN) begin
            pat_out <= cur_bit;
            idx     <= idx_nxt;
        end else begin
            pat_out <= 1'b0;
        end
    end

endmodule

// File: rtl/pattern_clk_gen.sv
module pattern_clk_gen
    import pcg_pkg::*;
#(
    parameter int unsigned PAT_W  = 32,
    parameter int unsigned HALF_W = PAT_W / 2,
    parameter logic [PAT_W-1:0] DEF_PAT = 32'h5555_5555
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              start,
    input  logic              stop,
    output logic              pat_out
);
    localparam int unsigned LIM_W = $clog2(PAT_W);
    localparam logic [LIM_W-1:0] DEF_LIM = LIM_W'(PAT_W - 1);

    logic [PAT_W-1:0] stg_pat;
    logic [LIM_W-1:0] stg_lim;
    logic [PAT_W-1:0] act_pat;
    logic [LIM_W-1:0] act_lim;
    logic [LIM_W-1:0] idx;
    logic             running;

    pcg_cfg_bank #(
        .PAT_W(PAT_W), .HALF_W(HALF_W), .LIM_W(LIM_W),
        .DEF_PAT(DEF_PAT), .DEF_LIM(DEF_LIM)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stg_pat(stg_pat), .stg_lim(stg_lim)
    );

    pcg_engine #(.PAT_W(PAT_W), .LIM_W(LIM_W)) u_eng (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .stg_pat(stg_pat), .stg_lim(stg_lim), .pat_out(pat_out),
        .running(running), .idx(idx), .act_lim(act_lim), .act_pat(act_pat)
    );

endmodule

// File: rtl/pattern_clk_gen_chk.sv
module pattern_clk_gen_chk #(
    parameter int unsigned PAT_W = 32,
    parameter int unsigned LIM_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stop,
    input logic             pat_out,
    input logic             running,
    input logic [LIM_W-1:0] idx,
    input logic [LIM_W-1:0] act_lim,
    input logic [PAT_W-1:0] act_pat
);
    // R5: stop without start forces low output and idle state
    a_r5_stop_low: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> (!pat_out && !running));

    // R7: start (even with stop) restarts at position 0 with a low lead cycle
    a_r7_start_restart: assert property (@(posedge clk) disable iff (rst)
        start |=> (running && idx == '0 && !pat_out));

    // R4: index never passes the active limit
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> (idx <= act_lim));

    // R4: wrap to position 0 right after the last position
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (running && !start && !stop && idx == act_lim) |=> (idx == '0));

    // R6: active settings hold while running without a restart
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (running && !start) |=> ($stable(act_pat) && $stable(act_lim)));

    // R2: output follows the bit selected in the previous cycle
    a_r2_bit_order: assert property (@(posedge clk) disable iff (rst)
        (running && !start && !stop) |=> (pat_out == $past(act_pat[idx])));

    // R5: idle output stays low
    a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> !pat_out);
endmodule

bind pattern_clk_gen pattern_clk_gen_chk #(.PAT_W(PAT_W), .LIM_W(LIM_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .pat_out(pat_out),
    .running(running), .idx(idx), .act_lim(act_lim), .act_pat(act_pat)
);

// File: tb/tb_pattern_clk_gen.sv
module tb_pattern_clk_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        pat_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_stg_pat, m_act_pat;
    int          m_stg_lim, m_act_lim, m_idx;
    bit          m_run, m_out;

    pattern_clk_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .start(start), .stop(stop), .pat_out(pat_out)
    );

    always #2 clk = ~clk;

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int next_pos(int cur, int lim);
        return (cur >= lim) ? 0 : cur + 1;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // advance one clock, update model with the inputs just sampled, compare
    task automatic tick(string tag);
        logic [31:0] sp;
        int          sl;
        @(posedge clk);
        sp = m_stg_pat;
        sl = m_stg_lim;
        if (wr_en) begin
            case (wr_sel)
                2'd0: m_stg_pat[15:0]  = wr_data;
                2'd1: m_stg_pat[31:16] = wr_data;
                2'd2: m_stg_lim        = int'(wr_data[4:0]);
                default: ;
            endcase
        end
        if (start) begin
            m_act_pat = sp; m_act_lim = sl; m_idx = 0; m_run = 1; m_out = 0;
        end else if (stop) begin
            m_run = 0; m_out = 0;
        end else if (m_run) begin
            m_out = m_act_pat[m_idx];
            m_idx = next_pos(m_idx, m_act_lim);
        end else begin
            m_out = 0;
        end
        #1;
        check(tag, pat_out, m_out);
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d, string tag);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick(tag);
        wr_en = 0;
    endtask

    task automatic go(string tag);
        start = 1; tick(tag); start = 0;
    endtask

    task automatic halt(string tag);
        stop = 1; tick(tag); stop = 0;
    endtask

    initial begin
        m_stg_pat = 32'h5555_5555; m_act_pat = '0;
        m_stg_lim = 31; m_act_lim = 0; m_idx = 0; m_run = 0; m_out = 0;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset output", pat_out, 1'b0);
        rst = 0;
        tick("R1 idle after reset");

        // R9 / R1: default pattern gives half rate starting with 1
        go("R2 lead cycle");
        for (int i = 0; i < 40; i++) begin
            tick("R9 default half rate");
            check("R9 toggle", pat_out, (i % 2 == 0));
        end

        // R5: stop holds low
        halt("R5 stop");
        for (int i = 0; i < 8; i++) tick("R5 stays low");

        // R4: limit 2 with single set bit -> period 3
        wr(2'd0, 16'h0001, "R3 low half write");
        wr(2'd2, 16'hFFE2, "R4 limit write");
        go("R4 start short");
        for (int i = 0; i < 12; i++) begin
            tick("R4 wrap");
            check("R4 period three", pat_out, (i % 3 == 0));
        end

        // R3 / R2: asymmetric halves, LSB first, high half at bits 31:16
        wr(2'd1, 16'h8001, "R3 high half write");
        wr(2'd0, 16'h0003, "R3 low half write");
        wr(2'd2, 16'd31, "R4 full length");
        go("R2 start");
        for (int i = 0; i < 64; i++) tick("R2 R3 bit order");

        // R6: writes while running do not change playback
        wr(2'd0, 16'hFFFF, "R6 write while running");
        wr(2'd1, 16'hFFFF, "R6 write while running");
        for (int i = 0; i < 40; i++) tick("R6 unchanged waveform");

        // R8: selector 3 ignored, verified after restart
        wr(2'd3, 16'h0000, "R8 ignored write");
        go("R7 restart while running");
        for (int i = 0; i < 40; i++) tick("R8 staged unchanged");

        // R7: start and stop together, start with write same cycle
        start = 1; stop = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 16'h0000;
        tick("R7 start beats stop");
        start = 0; stop = 0; wr_en = 0;
        for (int i = 0; i < 40; i++) tick("R7 old staged used");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom_range(0, 99);
            wr_en   = (r < 15);
            wr_sel  = 2'($urandom_range(0, 3));
            wr_data = 16'($urandom);
            start   = ($urandom_range(0, 99) < 3);
            stop    = ($urandom_range(0, 99) < 2);
            tick("R6 R7 random");
        end
        wr_en = 0; start = 0; stop = 0;
        halt("R5 final stop");
        tick("R5 final low");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule